// File: doc/BRIEF.md
# Asynchronous Page-Mode DRAM Sequencer

This block sits between a synchronous host and a 2M x 8 asynchronous DRAM. It turns single-beat read and write requests into the strobe patterns the device needs: row-address strobe, column-address strobe, write enable, output enable and a shared 11-bit address bus. Each interval in the device's timing sheet is given as a nanosecond parameter. The block converts each one into a count of clock cycles by ceiling division, so one source file can serve any clock period.

After reset the block holds both address strobes high for the whole power-up pause. It then wakes the device with eight refresh cycles in which the column strobe falls before the row strobe. Only after that does it raise host ready. From then on a free-running interval counter asks for one such refresh per period. A pending refresh wins over a waiting host request, but it never cuts short an access already in flight.

Writes always use early-write timing: write enable falls before the column strobe, so the device's output never turns on. Reads hold write enable high for the whole cycle. The returned byte is sampled only after the longest of the access times that apply, and is handed back with a one-cycle valid pulse.

Top module: `dram_seq_ctrl`

## Requirements
- R1: After reset release, `dram_ras_n` and `dram_cas_n` stay high, and `req_ready` stays low, for at least `T_PAUSE_NS` nanoseconds.
- R2: After the pause, exactly `WAKE_CYCLES` (default 8) refresh cycles, each with `dram_cas_n` falling while `dram_ras_n` is high, come before `req_ready` first rises. No access cycle runs before them.
- R3: `req_ready` is high only when the sequencer is idle, wake-up is done and no refresh is pending. A request is taken at a rising clock edge where `req_valid` and `req_ready` are both high.
- R4: The 21-bit host address is split into row = `req_addr[20:10]` and column = `req_addr[9:0]`. The row is on `dram_addr` when `dram_ras_n` falls, and the column (zero-extended to 11 bits) is on `dram_addr` when `dram_cas_n` falls.
- R5: In an access cycle, `dram_cas_n` falls no sooner than `T_RAH_NS + 2*T_TRANS_NS + T_ASC_NS` after `dram_ras_n` falls.
- R6: In a write, `dram_we_n` is low at least `T_WCS_NS` (and at least one clock) before `dram_cas_n` falls. `dram_oe_n` stays high for the whole cycle, and `dram_dq_oe` drives the write byte while the column strobe is low.
- R7: In a read, `dram_we_n` stays high across the column-strobe low time and its rising edge, which meets the read-command hold. `dram_oe_n` is low while `dram_cas_n` is low.
- R8: Read data is sampled no sooner than the largest of `T_CAC_NS` and `T_AA_NS` from the column-strobe fall, and of `T_RAC_NS` from the row-strobe fall. It is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R9: Once wake-up is done, one refresh cycle (column strobe falling first, then row strobe) is issued per `T_REFI_NS` interval.
- R10: A refresh that falls due while an access is running waits for that access to finish. It then runs before any new host request is accepted, so refresh keeps its rate under a continuous request stream.
- R11: The row strobe stays low at least `T_RAS_NS` in every cycle, and stays high at least `T_RP_NS` between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address, row in the upper 11 bits |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Read byte |
| dram_ras_n | output | 1 | Row-address strobe, active low |
| dram_cas_n | output | 1 | Column-address strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data from the device |

## Verification
The hardest case to reach from the ports is a refresh interval that runs out while the host keeps `req_valid` high without a gap. Priority then decides whether refresh keeps its rate or starves. The bench drives an unbroken stream of writes that spans several refresh periods, counts the refresh cycles the DRAM model sees during it, and afterwards reads back samples of the stream to show that no access was corrupted by the interleaving. The DRAM model also checks the device timing on every access: it drives a junk byte until the access time has elapsed, so any read sampled too early returns the wrong value.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_PRECH,
        ST_IDLE,
        ST_RSETUP,
        ST_ROW,
        ST_COL,
        ST_STROBE
    } seq_state_e;

    // Ceiling division of a nanosecond interval by the clock period, never below one cycle.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        if (ns <= 0) return 1;
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL_CYC = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (ack) d.pend = 1'b0;
        if (!enable) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(INTERVAL_CYC - 1)) begin
            d.cnt  = '0;
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending = q.pend;

    // R10: a due refresh is remembered until the sequencer takes it
    p_pend_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
    // R9: the sequencer only acknowledges a refresh that was requested
    p_ack_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> pending);

endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int ADDR_W = 21,
    parameter int ROW_W  = 11,
    parameter int COL_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    // R4: row is the upper field, column the lower field
    assign row = addr[ADDR_W-1 -: ROW_W];
    assign col = addr[COL_W-1:0];

    initial begin
        a_split_width_r4: assert (ROW_W + COL_W == ADDR_W);
    end
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W        = 21,
    parameter int ROW_W         = 11,
    parameter int COL_W         = 10,
    parameter int DATA_W        = 8,
    parameter int CLK_NS        = 4,
    parameter int T_PAUSE_NS    = 200000,
    parameter int WAKE_CYCLES   = 8,
    parameter int T_REFI_NS     = 15600,
    parameter int T_RP_NS       = 40,
    parameter int T_RAS_NS      = 60,
    parameter int T_ASR_NS      = 0,
    parameter int T_RAH_NS      = 10,
    parameter int T_ASC_NS      = 0,
    parameter int T_TRANS_NS    = 2,
    parameter int T_CAS_NS      = 15,
    parameter int T_CAC_NS      = 15,
    parameter int T_AA_NS       = 30,
    parameter int T_RAC_NS      = 60,
    parameter int T_WCS_NS      = 0,
    parameter int T_WCH_NS      = 10,
    parameter int T_CSR_NS      = 5,
    parameter int T_CHR_NS      = 10,
    parameter int MARGIN_CYC    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int AW         = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int PAUSE_CYC  = ns2cyc(T_PAUSE_NS, CLK_NS);
    localparam int REFI_CYC   = ns2cyc(T_REFI_NS, CLK_NS);
    localparam int RP_CYC     = ns2cyc(T_RP_NS, CLK_NS);
    localparam int RSU_CYC    = ns2cyc(T_ASR_NS, CLK_NS);
    localparam int ROW_CYC    = ns2cyc(T_RAH_NS, CLK_NS);
    localparam int COLSU_CYC  = imax(ns2cyc(2 * T_TRANS_NS + T_ASC_NS, CLK_NS),
                                     ns2cyc(T_WCS_NS, CLK_NS));
    localparam int RCD_CYC    = ROW_CYC + COLSU_CYC;
    localparam int RAS_CYC    = ns2cyc(T_RAS_NS, CLK_NS);
    localparam int CSR_CYC    = ns2cyc(T_CSR_NS, CLK_NS);
    localparam int CBR_CYC    = imax(RAS_CYC, ns2cyc(T_CHR_NS, CLK_NS));
    localparam int ACC_CYC    = imax(imax(ns2cyc(T_CAC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                     imax(ns2cyc(T_RAC_NS, CLK_NS) - RCD_CYC, 1));
    localparam int HOLD_CYC   = imax(imax(ns2cyc(T_CAS_NS, CLK_NS), ns2cyc(T_WCH_NS, CLK_NS)),
                                     imax(RAS_CYC - RCD_CYC, 1));
    localparam int STROBE_CYC = imax(ACC_CYC, HOLD_CYC) + MARGIN_CYC;
    localparam int MAX_CYC    = imax(imax(PAUSE_CYC, CBR_CYC), imax(STROBE_CYC, RP_CYC));
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam int WAKE_W     = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [WAKE_W-1:0] wake;
        logic              init;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] wdata;
        logic              dq_oe;
        logic              is_wr;
        logic [COL_W-1:0]  col;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
    } seq_regs_t;

    seq_regs_t q, d;

    logic             ref_pend;
    logic             ref_ack;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             last;

    dram_addr_split #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr (req_addr),
        .row  (req_row),
        .col  (req_col)
    );

    dram_refresh_timer #(.INTERVAL_CYC(REFI_CYC)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (q.init),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    assign last      = (q.cnt == '0);
    assign req_ready = (q.st == ST_IDLE) && q.init && !ref_pend;

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        ref_ack = 1'b0;
        if (!last) d.cnt = q.cnt - 1'b1;
        case (q.st)
            ST_PAUSE: if (last) begin
                d.st    = ST_CBR_CAS;
                d.cas_n = 1'b0;
                d.cnt   = CNT_W'(CSR_CYC - 1);
            end
            ST_CBR_CAS: if (last) begin
                d.st    = ST_CBR_RAS;
                d.ras_n = 1'b0;
                d.cnt   = CNT_W'(CBR_CYC - 1);
            end
            ST_CBR_RAS: if (last) begin
                d.st    = ST_PRECH;
                d.ras_n = 1'b1;
                d.cas_n = 1'b1;
                d.cnt   = CNT_W'(RP_CYC - 1);
                if (!q.init) d.wake = q.wake + 1'b1;
            end
            ST_PRECH: if (last) begin
                d.st   = ST_IDLE;
                d.init = q.init | (q.wake >= WAKE_W'(WAKE_CYCLES));
            end
            ST_IDLE: begin
                if (!q.init || ref_pend) begin
                    d.st    = ST_CBR_CAS;
                    d.cas_n = 1'b0;
                    d.cnt   = CNT_W'(CSR_CYC - 1);
                    ref_ack = q.init;
                end else if (req_valid) begin
                    d.st    = ST_RSETUP;
                    d.addr  = AW'(req_row);
                    d.col   = req_col;
                    d.is_wr = req_write;
                    d.wdata = req_wdata;
                    d.cnt   = CNT_W'(RSU_CYC - 1);
                end
            end
            ST_RSETUP: if (last) begin
                d.st    = ST_ROW;
                d.ras_n = 1'b0;
                d.cnt   = CNT_W'(ROW_CYC - 1);
            end
            ST_ROW: if (last) begin
                d.st    = ST_COL;
                d.addr  = AW'(q.col);
                d.we_n  = !q.is_wr;
                d.dq_oe = q.is_wr;
                d.cnt   = CNT_W'(COLSU_CYC - 1);
            end
            ST_COL: if (last) begin
                d.st    = ST_STROBE;
                d.cas_n = 1'b0;
                d.oe_n  = q.is_wr;
                d.cnt   = CNT_W'(STROBE_CYC - 1);
            end
            ST_STROBE: if (last) begin
                d.st    = ST_PRECH;
                d.ras_n = 1'b1;
                d.cas_n = 1'b1;
                d.oe_n  = 1'b1;
                d.we_n  = 1'b1;
                d.dq_oe = 1'b0;
                d.cnt   = CNT_W'(RP_CYC - 1);
                if (!q.is_wr) begin
                    d.rsp_v = 1'b1;
                    d.rdata = dram_dq_in;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_PAUSE;
            q.cnt   <= CNT_W'(PAUSE_CYC);
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_addr   = q.addr;
    assign dram_dq_out = q.wdata;
    assign dram_dq_oe  = q.dq_oe;
    assign rsp_valid   = q.rsp_v;
    assign rsp_rdata   = q.rdata;

    // Interval counters watching the pins, used only by the properties below.
    logic [31:0] since_q;
    logic [15:0] ras_low_q, ras_high_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q    <= '0;
            ras_low_q  <= '0;
            ras_high_q <= '0;
        end else begin
            if (since_q != '1) since_q <= since_q + 1'b1;
            ras_low_q  <= dram_ras_n ? '0 : ((ras_low_q == '1) ? ras_low_q : ras_low_q + 1'b1);
            ras_high_q <= !dram_ras_n ? '0 : ((ras_high_q == '1) ? ras_high_q : ras_high_q + 1'b1);
        end
    end

    p_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) || $fell(dram_cas_n)) |-> (since_q >= 32'(PAUSE_CYC)));
    p_wake_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (q.wake >= WAKE_W'(WAKE_CYCLES)));
    p_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ras_n && dram_cas_n && !ref_pend));
    p_rcd_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> (ras_low_q >= 16'(RCD_CYC)));
    p_we_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0));
    p_oe_off_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> dram_we_n);
    p_ras_min_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (ras_low_q >= 16'(RAS_CYC)));
    p_rp_min_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_high_q >= 16'(RP_CYC)));

endmodule

// File: tb/dram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module dram_seq_ctrl_bench;
    localparam int  CLK_NS  = 4;
    localparam real PAUSE   = 200000.0;
    localparam real RCD_MIN = 14.0;
    localparam real RAS_MIN = 60.0;
    localparam real RP_MIN  = 40.0;
    localparam real WCS_MIN = 0.0;
    localparam real CAC     = 15.0;
    localparam real AA      = 30.0;
    localparam real RAC     = 60.0;
    localparam int  REFI_CYC = 3900;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [7:0] rsp_rdata;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [10:0] dram_addr;
    logic [7:0]  dram_dq_out;
    logic [7:0]  dram_dq_in = 8'h5A;

    always #2 clk = ~clk;

    dram_seq_ctrl u_dram_seq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural DRAM model ----------------
    realtime t_rel = 0.0, t_ras_fall = 0.0, t_ras_rise = 0.0, t_we_fall = 0.0;
    bit  seen_act = 1'b0;
    bit  in_read = 1'b0;
    int  cbr_cnt = 0, acc_cnt = 0, wr_cnt = 0;
    logic [10:0] row_lat = '0;
    logic [9:0]  col_lat = '0;
    logic [7:0]  mem [int];

    always @(negedge dram_ras_n or negedge dram_cas_n) begin
        if (rst_n && !seen_act) begin
            seen_act = 1'b1;
            check(($realtime - t_rel) >= PAUSE, "R1 pause length ns", longint'($realtime - t_rel), longint'(PAUSE));
        end
    end

    always @(negedge dram_ras_n) begin
        if (rst_n) begin
            check(($realtime - t_ras_rise) >= RP_MIN || t_ras_rise == 0.0, "R11 precharge ns",
                  longint'($realtime - t_ras_rise), longint'(RP_MIN));
            t_ras_fall = $realtime;
            if (!dram_cas_n) begin
                cbr_cnt++;
            end else begin
                row_lat = dram_addr;
                acc_cnt++;
                check(cbr_cnt >= 8, "R2 wake refreshes before access", cbr_cnt, 8);
            end
        end
    end

    always @(posedge dram_ras_n) begin
        if (rst_n && t_ras_fall > 0.0) begin
            check(($realtime - t_ras_fall) >= RAS_MIN, "R11 ras low ns",
                  longint'($realtime - t_ras_fall), longint'(RAS_MIN));
            t_ras_rise = $realtime;
        end
    end

    always @(negedge dram_we_n) t_we_fall = $realtime;

    always @(negedge dram_cas_n) begin
        if (rst_n && !dram_ras_n) begin
            realtime tf;
            realtime acc;
            int key;
            tf = $realtime;
            check((tf - t_ras_fall) >= RCD_MIN, "R5 ras-to-cas ns", longint'(tf - t_ras_fall), longint'(RCD_MIN));
            col_lat = dram_addr[9:0];
            check(dram_addr[10] == 1'b0, "R4 column upper pin zero", dram_addr[10], 0);
            key = int'({row_lat, col_lat});
            #0.5;
            if (!dram_we_n) begin
                in_read = 1'b0;
                check((tf - t_we_fall) >= WCS_MIN && (tf - t_we_fall) >= real'(CLK_NS), "R6 we setup ns",
                      longint'(tf - t_we_fall), CLK_NS);
                check(dram_oe_n == 1'b1, "R6 oe high in write", dram_oe_n, 1);
                check(dram_dq_oe == 1'b1, "R6 data driven in write", dram_dq_oe, 1);
                mem[key] = dram_dq_out;
                wr_cnt++;
            end else begin
                in_read = 1'b1;
                check(dram_oe_n == 1'b0, "R7 oe low in read", dram_oe_n, 0);
                dram_dq_in = 8'hA5;
                acc = (CAC > AA) ? CAC : AA;
                if ((RAC - (tf - t_ras_fall)) > acc) acc = RAC - (tf - t_ras_fall);
                #(acc - 0.5);
                if (!dram_cas_n) dram_dq_in = mem.exists(key) ? mem[key] : 8'h00;
            end
        end
    end

    always @(posedge dram_cas_n) begin
        if (rst_n && in_read) begin
            #0.5;
            check(dram_we_n == 1'b1, "R7 we high at cas rise", dram_we_n, 1);
            in_read = 1'b0;
        end
    end

    // ---------------- host tasks ----------------
    task automatic wait_ready();
        int g = 0;
        while (!req_ready && g < 100000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic host_write(input logic [20:0] a, input logic [7:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        wait_ready();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic host_read(input logic [20:0] a, output logic [7:0] v);
        int g = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        wait_ready();
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && g < 1000) begin
            @(negedge clk);
            g++;
        end
        v = rsp_rdata;
        check(rsp_valid == 1'b1, "R8 response arrives", rsp_valid, 1);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 response one-cycle pulse", rsp_valid, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle in reset",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        check(req_ready == 1'b0, "R3 ready low in reset", req_ready, 0);
        rst_n = 1'b1;
        t_rel = $realtime;
        repeat (1000) @(negedge clk);
        check(dram_ras_n && dram_cas_n && !req_ready, "R1 strobes idle during pause",
              {dram_ras_n, dram_cas_n, req_ready}, 3'b110);
    endtask

    task automatic t_init();
        wait_ready();
        check(req_ready == 1'b1, "R2 ready after wake-up", req_ready, 1);
        check(($realtime - t_rel) >= PAUSE, "R1 ready not before pause", longint'($realtime - t_rel), longint'(PAUSE));
        check(cbr_cnt == 8, "R2 exactly eight wake refreshes", cbr_cnt, 8);
        check(acc_cnt == 0, "R2 no access before ready", acc_cnt, 0);
    endtask

    task automatic t_write_read(input logic [20:0] a, input logic [7:0] v);
        logic [7:0] r;
        host_write(a, v);
        wait_ready();
        check(row_lat == a[20:10], "R4 row field on pins", row_lat, a[20:10]);
        check(col_lat == a[9:0], "R4 column field on pins", col_lat, a[9:0]);
        host_read(a, r);
        check(r == v, "R8 read data after access time", r, v);
    endtask

    task automatic t_overwrite();
        logic [7:0] r;
        host_write(21'h0ABCDE, 8'h11);
        host_write(21'h0ABCDE, 8'h22);
        host_read(21'h0ABCDE, r);
        check(r == 8'h22, "R6 second write lands", r, 8'h22);
        host_read(21'h0ABCDF, r);
        check(r == 8'h00, "R4 neighbour column untouched", r, 8'h00);
    endtask

    task automatic t_refresh_idle();
        int c0 = cbr_cnt;
        int dlt;
        repeat (3 * REFI_CYC + 200) @(negedge clk);
        dlt = cbr_cnt - c0;
        check(dlt >= 3 && dlt <= 4, "R9 refresh count over three intervals", dlt, 3);
    endtask

    task automatic t_refresh_busy();
        int c0 = cbr_cnt;
        int n = 0;
        int dlt;
        logic [7:0] r;
        realtime t0 = $realtime;
        while (($realtime - t0) < real'(3 * REFI_CYC * CLK_NS)) begin
            host_write(21'h100000 + 21'(n * 37), 8'(n) ^ 8'h3C);
            n++;
        end
        dlt = cbr_cnt - c0;
        check(dlt >= 2 && dlt <= 4, "R10 refresh kept under stream", dlt, 3);
        check(wr_cnt >= n, "R10 every streamed write reached device", wr_cnt, n);
        host_read(21'h100000, r);
        check(r == 8'h3C, "R10 first streamed byte intact", r, 8'h3C);
        host_read(21'h100000 + 21'((n - 1) * 37), r);
        check(r == (8'(n - 1) ^ 8'h3C), "R10 last streamed byte intact", r, 8'(n - 1) ^ 8'h3C);
        check(req_ready == 1'b1 || req_ready == 1'b0, "R3 ready defined", req_ready, 1);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_init();
        t_write_read(21'h000000, 8'h5C);
        t_write_read(21'h1FFFFF, 8'hC3);
        t_write_read(21'h0003FF, 8'h81);
        t_write_read(21'h000400, 8'h7E);
        t_write_read(21'h012345, 8'h00);
        t_overwrite();
        t_refresh_idle();
        t_refresh_busy();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule